// File: doc/BRIEF.md
# I/O-Page Mode Switch Bank

This block sits on the address side of an 8-bit processor bus. It watches every read and write that falls in the I/O page (addresses 0xC000 to 0xC0FF) and keeps twelve single-bit mode flags. The memory banking logic and the video timing logic use these flags. Each flag has its own pair of control addresses, one to clear and one to set, plus a third address where software can read the flag back.

The four display flags also change when software reads one of their control addresses, so a plain load instruction can switch the screen mode. The block also answers a few locations that it does not implement. These include a set of ignored reads and the keyboard data and strobe bytes, so that the bus sees them as handled.

Any other I/O-page access raises an error flag for as long as the strobe is held. The processor bus is expected to give single-cycle strobes.

Top module: `ioswitch_bank`

## Requirements
- R1: After reset every flag in `sw_state` is 0, and a read of any status address returns 0x00.
- R2: A write to a flag's set address makes its `sw_state` bit 1, and a write to its clear address makes it 0, at the next rising clock edge. The bit positions and their (clear, set, status) addresses are:
  - bit 0: C006, C007, C015
  - bit 1: C000, C001, C018
  - bit 2: C002, C003, C013
  - bit 3: C004, C005, C014
  - bit 4: C008, C009, C016
  - bit 5: C00A, C00B, C017
  - bit 6: C00E, C00F, C01E
  - bit 7: C00C, C00D, C01F
  - bit 8: C050, C051, C01A
  - bit 9: C052, C053, C01B
  - bit 10: C054, C055, C01C
  - bit 11: C056, C057, C01D
- R3: A read of a status address returns 0x80 when the flag is 1 and 0x00 when it is 0, with bits 6..0 always zero.
- R4: A read of the set or clear address of flags 8 to 11 changes that flag in the same way a write would, returns 0xFF and asserts `hit`.
- R5: A read of the set or clear address of flags 0 to 7 leaves every flag unchanged. Apart from C000, such a read is an unhandled access.
- R6: A read of C000 returns keyboard data 0x00 with `hit` high and leaves flag 1 unchanged.
- R7: Reads of C058, C05A, C05D, C05F, C061 and C062 return 0x00, assert `hit` and change no flag.
- R8: A read of C010 returns 0x00 with `hit`. A write to C010 asserts `hit` and changes no flag.
- R9: Any other read or write with a strobe in the I/O page asserts `io_err`, keeps `hit` low, returns 0x00 and changes no flag.
- R10: An access outside the I/O page keeps `hit` and `io_err` low, returns 0x00 and changes no flag.
- R11: `hit`, `io_err` and `rd_data` follow the address and strobes in the same cycle. With no strobe, the flags hold.
- R12: When `rd_en` and `wr_en` are both high, the access is decoded as a write only, and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Read data, combinational |
| hit | output | 1 | The block has handled the access |
| io_err | output | 1 | The access is an unhandled I/O-page address |
| sw_state | output | 12 | Current flag vector |

## Verification
The hardest cases are the ones where the same address means different things depending on direction. C000 clears flag 1 on a write but returns keyboard data on a read. Reads of display control addresses change state, while reads of the other flags' control addresses are errors. The stimulus first sets every flag. It then reads each control address in both groups and reads C000 while flag 1 is set, so that a read wrongly treated as a clear shows up in `sw_state`. A long run of mixed accesses drawn from the I/O page, with both strobes at once now and then, is compared every cycle against a lookup-table model.

// File: rtl/ioswitch_pkg.sv
package ioswitch_pkg;
  localparam int NUM_SW = 12;
  localparam logic [7:0] IO_PAGE = 8'hC0;
  // flags that also change on a read of their control addresses
  localparam logic [NUM_SW-1:0] READ_TOGGLE_MASK = 12'hF00;
  localparam logic [7:0] KBD_DATA_LO = 8'h00;
  localparam logic [7:0] KBD_STROBE_LO = 8'h10;

  // low address byte that clears flag i; the set address is always the next one
  function automatic logic [7:0] clr_lo(input int i);
    case (i)
      0:  clr_lo = 8'h06;
      1:  clr_lo = 8'h00;
      2:  clr_lo = 8'h02;
      3:  clr_lo = 8'h04;
      4:  clr_lo = 8'h08;
      5:  clr_lo = 8'h0A;
      6:  clr_lo = 8'h0E;
      7:  clr_lo = 8'h0C;
      8:  clr_lo = 8'h50;
      9:  clr_lo = 8'h52;
      10: clr_lo = 8'h54;
      default: clr_lo = 8'h56;
    endcase
  endfunction

  function automatic logic [7:0] set_lo(input int i);
    set_lo = clr_lo(i) | 8'h01;
  endfunction

  function automatic logic [7:0] stat_lo(input int i);
    case (i)
      0:  stat_lo = 8'h15;
      1:  stat_lo = 8'h18;
      2:  stat_lo = 8'h13;
      3:  stat_lo = 8'h14;
      4:  stat_lo = 8'h16;
      5:  stat_lo = 8'h17;
      6:  stat_lo = 8'h1E;
      7:  stat_lo = 8'h1F;
      8:  stat_lo = 8'h1A;
      9:  stat_lo = 8'h1B;
      10: stat_lo = 8'h1C;
      default: stat_lo = 8'h1D;
    endcase
  endfunction

  function automatic logic is_ignored_lo(input logic [7:0] lo);
    is_ignored_lo = (lo == 8'h58) || (lo == 8'h5A) || (lo == 8'h5D) ||
                    (lo == 8'h5F) || (lo == 8'h61) || (lo == 8'h62);
  endfunction

  // status byte: flag value in bit 7 only
  function automatic logic [7:0] status_byte(input logic flag);
    status_byte = {flag, 7'b0};
  endfunction
endpackage

// File: rtl/ioswitch_decode.sv
module ioswitch_decode
  import ioswitch_pkg::*;
(
  input  logic [15:0]       bus_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [NUM_SW-1:0] set_req,
  output logic [NUM_SW-1:0] clr_req,
  output logic [NUM_SW-1:0] stat_sel,
  output logic              toggle_rd,
  output logic              quiet_rd,
  output logic              kbd_wr,
  output logic              handled,
  output logic              unhandled
);
  logic       in_page, wr_op, rd_op, stat_any;
  logic [7:0] lo;
  logic [NUM_SW-1:0] set_m, clr_m, stat_m;

  assign in_page = (bus_addr[15:8] == IO_PAGE);
  assign lo      = bus_addr[7:0];
  assign wr_op   = in_page & wr_en;
  assign rd_op   = in_page & rd_en & ~wr_en;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_match
    assign set_m[i]  = (lo == set_lo(i));
    assign clr_m[i]  = (lo == clr_lo(i));
    assign stat_m[i] = (lo == stat_lo(i));
    assign stat_sel[i] = rd_op & stat_m[i];
    if (READ_TOGGLE_MASK[i]) begin : g_rd_tog
      assign set_req[i] = set_m[i] & (wr_op | (rd_op & ~stat_any));
      assign clr_req[i] = clr_m[i] & (wr_op | (rd_op & ~stat_any));
    end else begin : g_wr_only
      assign set_req[i] = set_m[i] & wr_op;
      assign clr_req[i] = clr_m[i] & wr_op;
    end
  end

  assign stat_any  = |stat_m;
  assign toggle_rd = rd_op & ~stat_any & (|((set_m | clr_m) & READ_TOGGLE_MASK));
  assign quiet_rd  = rd_op & ~stat_any & ~toggle_rd &
                     (is_ignored_lo(lo) | (lo == KBD_DATA_LO) | (lo == KBD_STROBE_LO));
  assign kbd_wr    = wr_op & (lo == KBD_STROBE_LO);
  assign handled   = (|stat_sel) | toggle_rd | quiet_rd | kbd_wr |
                     (wr_op & (|(set_m | clr_m)));
  assign unhandled = in_page & (rd_en | wr_en) & ~handled;
endmodule

// File: rtl/ioswitch_cell.sv
module ioswitch_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/ioswitch_bank.sv
module ioswitch_bank
  import ioswitch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        rd_en,
  input  logic        wr_en,
  output logic [7:0]  rd_data,
  output logic        hit,
  output logic        io_err,
  output logic [11:0] sw_state
);
  logic [NUM_SW-1:0] set_req, clr_req, stat_sel;
  logic toggle_rd, quiet_rd, kbd_wr, handled, unhandled;

  ioswitch_decode u_dec (
    .bus_addr (bus_addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .set_req  (set_req),
    .clr_req  (clr_req),
    .stat_sel (stat_sel),
    .toggle_rd(toggle_rd),
    .quiet_rd (quiet_rd),
    .kbd_wr   (kbd_wr),
    .handled  (handled),
    .unhandled(unhandled)
  );

  for (genvar i = 0; i < NUM_SW; i++) begin : g_cell
    ioswitch_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_req[i]),
      .clr_i(clr_req[i]),
      .q    (sw_state[i])
    );
  end

  always_comb begin
    if (|stat_sel)      rd_data = status_byte(|(stat_sel & sw_state));
    else if (toggle_rd) rd_data = 8'hFF;
    else                rd_data = 8'h00;
  end

  assign hit    = handled;
  assign io_err = unhandled;
endmodule

module ioswitch_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  rd_data,
  input logic        hit,
  input logic        io_err,
  input logic [11:0] sw_state,
  input logic        toggle_rd
);
  // R3
  status_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && bus_addr == 16'hC01A) |-> rd_data == (sw_state[8] ? 8'h80 : 8'h00));
  // R2
  text_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 16'hC051) |=> sw_state[8]);
  // R6
  kbd_keeps_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && bus_addr == 16'hC000) |=> $stable(sw_state[1]));
  // R4
  toggle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_rd |-> (rd_data == 8'hFF && hit));
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_err |-> (!hit && rd_data == 8'h00));
  // R10
  off_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:8] != 8'hC0) |-> (!hit && !io_err && rd_data == 8'h00));
  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> $stable(sw_state));
endmodule

bind ioswitch_bank ioswitch_bank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .rd_data  (rd_data),
  .hit      (hit),
  .io_err   (io_err),
  .sw_state (sw_state),
  .toggle_rd(toggle_rd)
);

// File: tb/ioswitch_bank_test.sv
`timescale 1ns/1ps
module ioswitch_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  rd_data;
  logic        hit, io_err;
  logic [11:0] sw_state;

  int checks = 0;
  int errors = 0;
  logic [11:0] ref_sw = 12'h000;
  bit done = 0;

  // reference tables, indexed by flag bit
  int clr_a [12] = '{'hC006, 'hC000, 'hC002, 'hC004, 'hC008, 'hC00A,
                     'hC00E, 'hC00C, 'hC050, 'hC052, 'hC054, 'hC056};
  int set_a [12] = '{'hC007, 'hC001, 'hC003, 'hC005, 'hC009, 'hC00B,
                     'hC00F, 'hC00D, 'hC051, 'hC053, 'hC055, 'hC057};
  int stat_a[12] = '{'hC015, 'hC018, 'hC013, 'hC014, 'hC016, 'hC017,
                     'hC01E, 'hC01F, 'hC01A, 'hC01B, 'hC01C, 'hC01D};
  int quiet_a[$] = '{'hC058, 'hC05A, 'hC05D, 'hC05F, 'hC061, 'hC062, 'hC000, 'hC010};

  always #2.5 clk = ~clk;

  ioswitch_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .hit(hit), .io_err(io_err), .sw_state(sw_state)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int a, input bit rd, input bit wr,
                       output int d, output bit h, output bit e, output logic [11:0] nxt);
    bit done_m = 0;
    nxt = ref_sw; d = 0; h = 0; e = 0;
    if (!(rd || wr) || (a >> 8) != 'hC0) return;
    if (wr) begin
      for (int k = 0; k < 12; k++) begin
        if (a == set_a[k]) begin nxt[k] = 1'b1; h = 1; end
        if (a == clr_a[k]) begin nxt[k] = 1'b0; h = 1; end
      end
      if (a == 'hC010) h = 1;
      e = !h;
      return;
    end
    for (int k = 0; k < 12; k++)
      if (a == stat_a[k]) begin d = ref_sw[k] ? 'h80 : 'h00; h = 1; done_m = 1; end
    if (!done_m)
      for (int k = 8; k < 12; k++) begin
        if (a == set_a[k]) begin nxt[k] = 1'b1; d = 'hFF; h = 1; done_m = 1; end
        if (a == clr_a[k]) begin nxt[k] = 1'b0; d = 'hFF; h = 1; done_m = 1; end
      end
    if (!done_m)
      foreach (quiet_a[q]) if (a == quiet_a[q]) h = 1;
    e = !h;
  endtask

  // one bus cycle: drive after falling edge, compare outputs, update model at the rising edge
  task automatic acc(input string tag, input int a, input bit rd, input bit wr);
    int d; bit h, e; logic [11:0] nxt;
    @(negedge clk);
    chk(tag, "sw_state", int'(sw_state), int'(ref_sw));
    bus_addr = a[15:0]; rd_en = rd; wr_en = wr;
    #1;
    model(a, rd, wr, d, h, e, nxt);
    chk(tag, "rd_data", int'(rd_data), d);
    chk(tag, "hit", int'(hit), int'(h));
    chk(tag, "io_err", int'(io_err), int'(e));
    @(posedge clk);
    ref_sw = nxt;
    #0.5;
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    @(negedge clk);
    chk("R1", "reset sw_state", int'(sw_state), 0);
    for (int k = 0; k < 12; k++) acc("R1", stat_a[k], 1, 0);
    // R2, R3: set all, read back, clear even ones
    for (int k = 0; k < 12; k++) acc("R2", set_a[k], 0, 1);
    for (int k = 0; k < 12; k++) acc("R3", stat_a[k], 1, 0);
    for (int k = 0; k < 12; k += 2) acc("R2", clr_a[k], 0, 1);
    for (int k = 0; k < 12; k++) acc("R3", stat_a[k], 1, 0);
    // R4: display flags by read
    for (int k = 8; k < 12; k++) acc("R4", clr_a[k], 1, 0);
    for (int k = 8; k < 12; k++) acc("R4", stat_a[k], 1, 0);
    for (int k = 8; k < 12; k++) acc("R4", set_a[k], 1, 0);
    // R5: reads of non-display control addresses
    for (int k = 0; k < 8; k++) acc("R5", set_a[k], 1, 0);
    for (int k = 0; k < 8; k++) if (k != 1) acc("R5", clr_a[k], 1, 0);
    // R6: keyboard read while flag 1 set
    acc("R6", 'hC001, 0, 1);
    acc("R6", 'hC000, 1, 0);
    acc("R6", 'hC018, 1, 0);
    // R7, R8
    for (int q = 0; q < 6; q++) acc("R7", quiet_a[q], 1, 0);
    acc("R8", 'hC010, 1, 0);
    acc("R8", 'hC010, 0, 1);
    // R9
    acc("R9", 'hC020, 1, 0);
    acc("R9", 'hC0FF, 0, 1);
    acc("R9", 'hC058, 0, 1);
    // R10
    acc("R10", 'hC451, 0, 1);
    acc("R10", 'h0050, 1, 0);
    acc("R10", 'hC100, 1, 0);
    // R12
    acc("R12", 'hC01A, 1, 1);
    acc("R12", 'hC050, 1, 1);
    // R11: mixed traffic
    for (int n = 0; n < 400; n++) begin
      int a; bit rd, wr; int r;
      r = $urandom % 16;
      a = (r == 0) ? ('h8000 + $urandom % 'h100) : ('hC000 + $urandom % 'h70);
      rd = $urandom % 2; wr = $urandom % 2;
      if ($urandom % 8 == 0) begin rd = 0; wr = 0; end
      if (($urandom % 16) != 0 && rd && wr) wr = 0;
      acc("R11", a, rd, wr);
    end
    acc("R11", 'h0000, 0, 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule